// File: doc/BRIEF.md
# Timed Serial Register-Access Master

This block is the host side of a four-wire register link: chip select (active low), serial clock, data out to the device and data back from the device. A request names a direction, a 5-bit register address, a byte count and up to three bytes of write data. The master sends a command byte, then either shifts out the write bytes or clocks in the read bytes. It returns the read data, right-aligned, with a one-cycle done pulse.

The target device needs several minimum intervals. Some are in the nanosecond range: serial clock pulse widths, chip-select setup and hold. Others are in the microsecond range: gaps between bytes, the pause between a read command and its data, and a tail after a write. Each interval is a parameter counted in system clock cycles and rounded up by the integrator. The master holds every phase for exactly its programmed count, so each interval on the pins is fixed and can be measured.

Serial clock idles high. The master changes its data output only on a serial-clock rising edge. Both sides use the falling edge: the device samples there and the master captures the returned bit there. Bits travel most significant first.

Top module: `ser_reg_master`

## Requirements
- R1: The first 8 bits sent on `din` of every transfer form the command byte, sent MSB first: bit 7 is 1 for a write and 0 for a read, bits 6 and 5 are 0, and bits 4..0 are the address.
- R2: A write sends the low N bytes of `req_wdata` after the command byte, higher byte first and MSB first, where N is `req_nbytes`. A count of 0 is handled as 1. The transfer has exactly 8*(N+1) serial clock falling edges.
- R3: `sclk` is high whenever `cs_n` is high. Every low phase of `sclk` lasts exactly T_SCLK_LOW cycles. Inside a byte, every high phase between two falling edges lasts exactly T_SCLK_HIGH cycles.
- R4: The first `sclk` falling edge comes exactly T_CS_SETUP cycles after `cs_n` falls.
- R5: `din` changes only while `sclk` is high. It holds its value through the cycle in which `sclk` falls and through the whole low phase.
- R6: Between two write bytes, and between two read data bytes, `sclk` stays high for exactly T_BYTE_GAP cycles, counted from the last rising edge of one byte to the first falling edge of the next.
- R7: In a read, `sclk` stays high for exactly T_CMD_GAP cycles between the last rising edge of the command byte and the first falling edge of the data.
- R8: In a read, `dout` is captured at each data-bit falling edge, MSB first. From the done pulse until the next request, `rdata` holds the N captured bytes right-aligned, with the upper bits 0.
- R9: `cs_n` rises exactly T_CS_HOLD cycles after the last `sclk` rising edge, which is T_SCLK_LOW + T_CS_HOLD cycles after the last falling edge.
- R10: For a read, `done` pulses in the same cycle that `cs_n` rises. For a write, `done` pulses exactly T_WR_TAIL cycles after `cs_n` rises.
- R11: `busy` rises in the cycle after a request is accepted and is low again when `done` pulses. `done` lasts one cycle. A request made while `busy` is high is ignored and starts no transfer.
- R12: After reset, `cs_n` and `sclk` are high, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_nbytes | input | 2 | Data byte count 1..3 (0 handled as 1) |
| req_wdata | input | 24 | Write data, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 24 | Read data, right-aligned |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial data to the device |
| dout | input | 1 | Serial data from the device |

## Verification
The bench builds the master with small timing counts that all differ from one another: setup 3, high 4, low 5, hold 6, byte gap 20, tail 25 and command gap 30. Each interval measured on the pins can therefore be traced to exactly one parameter. The bench can tell if the command-to-data pause was swapped with the ordinary byte gap, if the hold was merged with a low phase, or if the tail was skipped. Because the gaps are short, all three byte counts in both directions fit in a short run, along with the zero-count case and requests made while busy.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int ADDR_W    = 5;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 3;
    localparam int DATA_W    = BYTE_W * MAX_BYTES;
    localparam int FRAME_W   = BYTE_W + DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_HOLD,
        ST_TAIL
    } ser_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        nbytes;
    } ser_req_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [1:0] eff_bytes(input logic [1:0] n);
        return (n == 2'd0) ? 2'd1 : n;
    endfunction

    function automatic logic [BYTE_W-1:0] cmd_byte(input logic wr,
                                                   input logic [ADDR_W-1:0] a);
        return {wr, 2'b00, a};
    endfunction

    // Command byte followed by the data bytes, left-aligned so the MSB leaves first.
    function automatic logic [FRAME_W-1:0] build_frame(input logic wr,
                                                      input logic [ADDR_W-1:0] a,
                                                      input logic [1:0] n,
                                                      input logic [DATA_W-1:0] data);
        logic [DATA_W-1:0] aligned;
        aligned = data << (BYTE_W * (MAX_BYTES - int'(n)));
        if (!wr) aligned = '0;
        return {cmd_byte(wr, a), aligned};
    endfunction

endpackage

// File: rtl/ser_gap_timer.sv
module ser_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift
    import ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic               tx_shift,
    input  logic               rx_shift,
    input  logic               rx_bit,
    output logic               tx_bit,
    output logic [DATA_W-1:0]  rx_data
);
    logic [FRAME_W-1:0] tx_q;
    logic [DATA_W-1:0]  rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)          tx_q <= load_frame;
            else if (tx_shift) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            if (load)          rx_q <= '0;
            else if (rx_shift) rx_q <= {rx_q[DATA_W-2:0], rx_bit};
        end
    end

    assign tx_bit  = tx_q[FRAME_W-1];
    assign rx_data = rx_q;
endmodule

// File: rtl/ser_reg_master.sv
module ser_reg_master
    import ser_pkg::*;
#(
    parameter int T_CS_SETUP  = 2,
    parameter int T_SCLK_HIGH = 15,
    parameter int T_SCLK_LOW  = 15,
    parameter int T_BYTE_GAP  = 400,
    parameter int T_CMD_GAP   = 400,
    parameter int T_CS_HOLD   = 10,
    parameter int T_WR_TAIL   = 640
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_nbytes,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              cs_n,
    output logic              sclk,
    output logic              din,
    input  logic              dout
);
    localparam int TMAX = max_of(max_of(max_of(T_CS_SETUP, T_SCLK_HIGH),
                                        max_of(T_SCLK_LOW, T_BYTE_GAP)),
                                 max_of(max_of(T_CMD_GAP, T_CS_HOLD), T_WR_TAIL));
    localparam int TW = $clog2(TMAX + 1);

    localparam logic [TW-1:0] LD_SETUP = TW'(T_CS_SETUP - 1);
    localparam logic [TW-1:0] LD_HIGH  = TW'(T_SCLK_HIGH - 1);
    localparam logic [TW-1:0] LD_LOW   = TW'(T_SCLK_LOW - 1);
    localparam logic [TW-1:0] LD_GAP   = TW'(T_BYTE_GAP - 1);
    localparam logic [TW-1:0] LD_CMD   = TW'(T_CMD_GAP - 1);
    localparam logic [TW-1:0] LD_HOLD  = TW'(T_CS_HOLD - 1);
    localparam logic [TW-1:0] LD_TAIL  = TW'(T_WR_TAIL - 1);

    ser_state_e st;
    ser_req_t   req_q;
    logic [2:0] bit_idx;
    logic [1:0] byte_idx;
    logic       cs_n_q, sclk_q, done_q;

    logic          t_load, t_exp;
    logic [TW-1:0] t_val;
    logic          accept, tx_shift, rx_shift, last_bit, last_byte;
    logic [FRAME_W-1:0] frame;

    assign accept    = (st == ST_IDLE) && req_valid;
    assign last_bit  = (bit_idx == 3'd7);
    assign last_byte = (byte_idx == req_q.nbytes);
    assign frame     = build_frame(req_write, req_addr, eff_bytes(req_nbytes), req_wdata);
    assign tx_shift  = (st == ST_LOW) && t_exp;
    assign rx_shift  = ((st == ST_HIGH) || (st == ST_GAP)) && t_exp
                       && !req_q.wr && (byte_idx != 2'd0);

    // Every phase lasts exactly its count: the timer is loaded with count-1 on entry.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        case (st)
            ST_IDLE: if (req_valid) begin
                t_load = 1'b1;
                t_val  = LD_SETUP;
            end
            ST_SETUP, ST_HIGH, ST_GAP: if (t_exp) begin
                t_load = 1'b1;
                t_val  = LD_LOW;
            end
            ST_LOW: if (t_exp) begin
                t_load = 1'b1;
                if (!last_bit)                           t_val = LD_HIGH;
                else if (last_byte)                      t_val = LD_HOLD;
                else if (!req_q.wr && byte_idx == 2'd0)  t_val = LD_CMD;
                else                                     t_val = LD_GAP;
            end
            ST_HOLD: if (t_exp && req_q.wr) begin
                t_load = 1'b1;
                t_val  = LD_TAIL;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            req_q    <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            cs_n_q   <= 1'b1;
            sclk_q   <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    req_q    <= '{wr: req_write, addr: req_addr,
                                  nbytes: eff_bytes(req_nbytes)};
                    bit_idx  <= '0;
                    byte_idx <= '0;
                    cs_n_q   <= 1'b0;
                    st       <= ST_SETUP;
                end
                ST_SETUP, ST_HIGH, ST_GAP: if (t_exp) begin
                    sclk_q <= 1'b0;
                    st     <= ST_LOW;
                end
                ST_LOW: if (t_exp) begin
                    sclk_q  <= 1'b1;
                    bit_idx <= bit_idx + 3'd1;
                    if (!last_bit)      st <= ST_HIGH;
                    else if (last_byte) st <= ST_HOLD;
                    else begin
                        byte_idx <= byte_idx + 2'd1;
                        st       <= ST_GAP;
                    end
                end
                ST_HOLD: if (t_exp) begin
                    cs_n_q <= 1'b1;
                    if (req_q.wr) st <= ST_TAIL;
                    else begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                ST_TAIL: if (t_exp) begin
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    ser_gap_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    ser_frame_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_frame (frame),
        .tx_shift   (tx_shift),
        .rx_shift   (rx_shift),
        .rx_bit     (dout),
        .tx_bit     (din),
        .rx_data    (rdata)
    );

    assign busy = (st != ST_IDLE);
    assign done = done_q;
    assign cs_n = cs_n_q;
    assign sclk = sclk_q;
endmodule

// File: rtl/ser_reg_master_chk.sv
module ser_reg_master_chk #(
    parameter int T_SCLK_LOW = 15
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic din,
    input logic busy,
    input logic done
);
    int low_run;

    always_ff @(posedge clk) begin
        if (rst)        low_run <= 0;
        else if (!sclk) low_run <= low_run + 1;
        else            low_run <= 0;
    end

    assert_idle_clock_high_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    assert_low_width_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> (low_run == T_SCLK_LOW));

    assert_din_quiet_low_R5: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> $stable(din));

    assert_cs_rise_clock_high_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> sclk);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_selects_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !cs_n);
endmodule

bind ser_reg_master ser_reg_master_chk #(.T_SCLK_LOW(T_SCLK_LOW)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .sclk (sclk),
    .din  (din),
    .busy (busy),
    .done (done)
);

// File: tb/sim_ser_reg_master.sv
module sim_ser_reg_master;
    import ser_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int P_SETUP = 3;
    localparam int P_HIGH  = 4;
    localparam int P_LOW   = 5;
    localparam int P_GAP   = 20;
    localparam int P_CMD   = 30;
    localparam int P_HOLD  = 6;
    localparam int P_TAIL  = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [1:0]  req_nbytes = '0;
    logic [23:0] req_wdata = '0;
    logic busy, done, cs_n, sclk, din;
    logic [23:0] rdata;
    logic dout = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_reg_master #(
        .T_CS_SETUP(P_SETUP), .T_SCLK_HIGH(P_HIGH), .T_SCLK_LOW(P_LOW),
        .T_BYTE_GAP(P_GAP), .T_CMD_GAP(P_CMD), .T_CS_HOLD(P_HOLD), .T_WR_TAIL(P_TAIL)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_nbytes(req_nbytes), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .cs_n(cs_n), .sclk(sclk),
        .din(din), .dout(dout)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pin monitor and device model, all on the falling clock edge.
    int cyc = 0;
    logic pcs = 1'b1, psclk = 1'b1, pdone = 1'b0;
    int fall_t[40];
    int rise_t[40];
    int nf = 0, nr = 0;
    int csf_t = 0, csr_t = 0, done_t = 0, cs_falls = 0, done_cycles = 0;
    logic [39:0] bits = '0;
    logic [23:0] sdata = '0;

    always @(negedge clk) begin
        cyc++;
        if (pcs && !cs_n) begin
            csf_t = cyc; cs_falls++; nf = 0; nr = 0; bits = '0; done_cycles = 0;
        end
        if (psclk && !sclk) begin
            if (nf < 40) fall_t[nf] = cyc;
            bits = {bits[38:0], din};
            nf++;
        end
        if (!psclk && sclk) begin
            if (nr < 40) rise_t[nr] = cyc;
            nr++;
            if (nf >= 8 && nf < 32) dout = sdata[23 - (nf - 8)];
        end
        if (!pcs && cs_n) csr_t = cyc;
        if (done) begin
            done_cycles++;
            if (!pdone) done_t = cyc;
        end
        pcs = cs_n; psclk = sclk; pdone = done;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_txn(input bit wr, input logic [4:0] a, input logic [1:0] n,
                           input logic [23:0] wd, input logic [23:0] sd, input bit poke);
        int ne;
        int falls_before;
        int w;
        logic [23:0] mask;
        ne = (n == 2'd0) ? 1 : int'(n);
        mask = 24'hFFFFFF >> (8 * (3 - ne));
        sdata = sd << (8 * (3 - ne));
        falls_before = cs_falls;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_nbytes = n; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
        if (poke) begin
            req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_nbytes = 2'd3;
            repeat (6) @(negedge clk);
            req_valid = 1'b0;
        end
        w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(done == 1'b1, "R10", "done seen", done, 1);
        chk(busy == 1'b0, "R11", "busy low at done", busy, 0);
        repeat (4) @(negedge clk);
        chk(done_cycles == 1, "R11", "done width", done_cycles, 1);
        chk(cs_falls - falls_before == 1, "R11", "transfers started", cs_falls - falls_before, 1);
        chk(nf == 8 * (ne + 1), "R2", "falling edge count", nf, 8 * (ne + 1));
        chk(bits[nf-1 -: 8] == {wr, 2'b00, a}, "R1", "command byte", bits[nf-1 -: 8], {wr, 2'b00, a});
        if (wr)
            chk((bits[23:0] & mask) == (wd & mask), "R2", "write data", bits[23:0] & mask, wd & mask);
        else
            chk(rdata == (sd & mask), "R8", "read data", rdata, sd & mask);
        chk(fall_t[0] - csf_t == P_SETUP, "R4", "cs to first fall", fall_t[0] - csf_t, P_SETUP);
        for (int i = 0; i < nf && i < 40; i++)
            chk(rise_t[i] - fall_t[i] == P_LOW, "R3", "low width", rise_t[i] - fall_t[i], P_LOW);
        for (int i = 0; i < nf - 1 && i < 39; i++) begin
            if (i % 8 != 7)
                chk(fall_t[i+1] - rise_t[i] == P_HIGH, "R3", "high width", fall_t[i+1] - rise_t[i], P_HIGH);
            else if (!wr && i == 7)
                chk(fall_t[i+1] - rise_t[i] == P_CMD, "R7", "command gap", fall_t[i+1] - rise_t[i], P_CMD);
            else
                chk(fall_t[i+1] - rise_t[i] == P_GAP, "R6", "byte gap", fall_t[i+1] - rise_t[i], P_GAP);
        end
        chk(csr_t - rise_t[nr-1] == P_HOLD, "R9", "cs hold", csr_t - rise_t[nr-1], P_HOLD);
        chk(done_t - csr_t == (wr ? P_TAIL : 0), "R10", "done delay", done_t - csr_t, wr ? P_TAIL : 0);
        chk(cs_n == 1'b1 && sclk == 1'b1, "R3", "idle pins after transfer", {cs_n, sclk}, 3);
    endtask

    task automatic test_reset();
        chk(cs_n == 1'b1, "R12", "cs_n in reset", cs_n, 1);
        chk(sclk == 1'b1, "R12", "sclk in reset", sclk, 1);
        chk(busy == 1'b0, "R12", "busy in reset", busy, 0);
        chk(done == 1'b0, "R12", "done in reset", done, 0);
    endtask

    task automatic test_write_two();   run_txn(1'b1, 5'h15, 2'd2, 24'h12A55A, 24'h0, 1'b0); endtask
    task automatic test_write_three(); run_txn(1'b1, 5'h0A, 2'd3, 24'hC3_3C_81, 24'h0, 1'b0); endtask
    task automatic test_write_zero();  run_txn(1'b1, 5'h1F, 2'd0, 24'hFFFF96, 24'h0, 1'b0); endtask
    task automatic test_read_one();    run_txn(1'b0, 5'h03, 2'd1, 24'h0, 24'h00006B, 1'b0); endtask
    task automatic test_read_three();  run_txn(1'b0, 5'h11, 2'd3, 24'h0, 24'hA5C30F, 1'b0); endtask
    task automatic test_read_busy();   run_txn(1'b0, 5'h06, 2'd2, 24'h0, 24'h00E71D, 1'b1); endtask
    task automatic test_write_busy();  run_txn(1'b1, 5'h19, 2'd1, 24'h0000B2, 24'h0, 1'b1); endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        test_reset();
        test_write_two();
        test_write_three();
        test_write_zero();
        test_read_one();
        test_read_three();
        test_read_busy();
        test_write_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule